// File: doc/BRIEF.md
# Store-Interface Message Checksum Unit

This block sits in the word stream between a remote terminal's protocol sequencer and its message buffer. It protects each store-interface message with a 16-bit checksum carried in the final data word. Words flow through the block on a valid/ready stream. A direction input selects whether the current message is being transmitted or received. On transmit, the block builds a running value from the outgoing words and puts the computed checksum in place of the final word. On receive, it folds every word, including the checksum word, into the running value. After the last word it reports whether the message passed.

The running value starts at zero for every message. For each accepted word, the value is rotated left by one bit and then XORed with the word. A received message passes when the value after its last word is zero. Checksum operation is active only while the active-low enable input is low. A link option routes a failed check to an illegal-message flag. The downstream buffer uses that flag to discard the data and to set the chosen status bit.

The stream has no storage of its own. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A word counts as accepted only in a cycle where both valid and ready are high, and the upstream side must hold the word steady while ready is low.

Top module: `msg_cksum_unit`

## Requirements
- R1: After reset, `cksum_ok` and `msg_illegal` are 0 and the running value is 0.
- R2: When `in_valid`=1 and `in_ready`=0, no word is accepted and the running value does not advance. `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle.
- R3: The running value is updated once per accepted word as rotate-left-by-one followed by XOR with the word. It returns to zero after each accepted word with `in_last`=1.
- R4: With `dir_tx`=1 and `cksum_en_n`=0, the word accepted with `in_last`=1 leaves the block as the running value of all preceding words rotated left by one bit. This makes the whole transmitted message fold to zero. A one-word message therefore sends 0x0000.
- R5: Words other than that substituted final word leave the block unchanged on `out_data`, and `out_last` equals `in_last`.
- R6: With `dir_tx`=0 and `cksum_en_n`=0, `cksum_ok` is 1 from the cycle after the last word is accepted exactly when the folded value including that word is zero. Otherwise it is 0.
- R7: `cksum_ok` and `msg_illegal` change only on the cycle after a received last word is accepted. Transmitted messages leave them unchanged.
- R8: With `link_illegal`=1, a received message that is checked and fails sets `msg_illegal` to 1 after its last word. A passing message sets `msg_illegal` to 0.
- R9: With `link_illegal`=0, a failed check leaves `msg_illegal` at 0.
- R10: With `cksum_en_n`=1, every transmitted word passes unchanged and a received last word leaves both `cksum_ok` and `msg_illegal` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cksum_en_n | input | 1 | Checksum enable, active low |
| link_illegal | input | 1 | Route a failed check to `msg_illegal` |
| dir_tx | input | 1 | 1 = transmit message, 0 = receive message |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 16 | Upstream word |
| in_last | input | 1 | Final word of the message |
| out_valid | output | 1 | Downstream word valid |
| out_ready | input | 1 | Downstream can take a word |
| out_data | output | 16 | Word passed on, checksum on transmit final word |
| out_last | output | 1 | Final word marker passed on |
| cksum_ok | output | 1 | Registered pass flag of the last received message |
| msg_illegal | output | 1 | Registered failed-and-linked flag of the last received message |

## Verification
The assertions check on every cycle that the stream handshake passes straight through and that each transmitted message folds to zero. They use a shadow fold that the checker keeps of the output words. They also check that the running value is back at zero after every last word, that the two flags move only after a received last word, and that the flags stay quiet when checking is off. Only the bench's scenarios can show the actual value of a flag for a given message: the pass of a good received message, the failure of a corrupted one with and without the link, and the exact checksum word for a known word sequence. The bench also exercises stalls under back-pressure in the middle of a message and the one-word message.

// File: rtl/cks_pkg.sv
package cks_pkg;
  localparam int CKS_W = 16;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } cks_dir_e;

  function automatic logic [CKS_W-1:0] rotl1(input logic [CKS_W-1:0] x);
    return {x[CKS_W-2:0], x[CKS_W-1]};
  endfunction
endpackage

// File: rtl/cks_accum.sv
module cks_accum #(
  parameter int W = cks_pkg::CKS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         beat,
  input  logic         last,
  input  logic [W-1:0] word,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] acc_rot,
  output logic [W-1:0] acc_next
);
  always_comb begin
    acc_rot  = {acc_q[W-2:0], acc_q[W-1]};
    acc_next = acc_rot ^ word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (beat)
      acc_q <= last ? '0 : acc_next;
  end
endmodule

// File: rtl/cks_tx_insert.sv
module cks_tx_insert #(
  parameter int W = cks_pkg::CKS_W
) (
  input  logic         active,
  input  logic         dir_tx,
  input  logic         last,
  input  logic [W-1:0] word,
  input  logic [W-1:0] acc_rot,
  output logic [W-1:0] word_out
);
  logic subst;

  always_comb begin
    subst    = active && dir_tx && last;
    word_out = subst ? acc_rot : word;
  end
endmodule

// File: rtl/cks_rx_judge.sv
module cks_rx_judge #(
  parameter int W = cks_pkg::CKS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         link,
  input  logic         dir_tx,
  input  logic         beat,
  input  logic         last,
  input  logic [W-1:0] acc_next,
  output logic         ok_q,
  output logic         illegal_q
);
  logic judge;
  logic zero;

  always_comb begin
    judge = beat && last && !dir_tx;
    zero  = (acc_next == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q      <= 1'b0;
      illegal_q <= 1'b0;
    end else if (judge) begin
      ok_q      <= active && zero;
      illegal_q <= active && link && !zero;
    end
  end
endmodule

// File: rtl/msg_cksum_unit.sv
module msg_cksum_unit #(
  parameter int W = cks_pkg::CKS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cksum_en_n,
  input  logic         link_illegal,
  input  logic         dir_tx,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         cksum_ok,
  output logic         msg_illegal
);
  logic         beat;
  logic         active;
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_rot;
  logic [W-1:0] acc_next;

  always_comb begin
    in_ready  = out_ready;
    out_valid = in_valid;
    out_last  = in_last;
    beat      = in_valid && out_ready;
    active    = !cksum_en_n;
  end

  cks_accum #(.W(W)) u_accum (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(in_last), .word(in_data),
    .acc_q(acc_q), .acc_rot(acc_rot), .acc_next(acc_next)
  );

  cks_tx_insert #(.W(W)) u_insert (
    .active(active), .dir_tx(dir_tx), .last(in_last), .word(in_data),
    .acc_rot(acc_rot), .word_out(out_data)
  );

  cks_rx_judge #(.W(W)) u_judge (
    .clk(clk), .rst_n(rst_n), .active(active), .link(link_illegal),
    .dir_tx(dir_tx), .beat(beat), .last(in_last), .acc_next(acc_next),
    .ok_q(cksum_ok), .illegal_q(msg_illegal)
  );
endmodule

// File: rtl/msg_cksum_unit_chk.sv
module msg_cksum_unit_chk #(
  parameter int W = cks_pkg::CKS_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cksum_en_n,
  input logic         link_illegal,
  input logic         dir_tx,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         in_last,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_last,
  input logic         cksum_ok,
  input logic         msg_illegal,
  input logic [W-1:0] acc_q
);
  logic         c_beat;
  logic [W-1:0] sh_q;
  logic [W-1:0] sh_next;

  always_comb begin
    c_beat  = in_valid && in_ready;
    sh_next = {sh_q[W-2:0], sh_q[W-1]} ^ out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sh_q <= '0;
    else if (c_beat && out_valid && out_ready)
      sh_q <= out_last ? '0 : sh_next;
  end

  AST_HANDSHAKE_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready)); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(acc_q)); // R2

  AST_CLEAR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (c_beat && in_last) |=> (acc_q == '0)); // R3

  AST_TX_FOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (c_beat && dir_tx && !cksum_en_n && in_last) |-> (sh_next == '0)); // R4

  AST_MID_WORD_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    !in_last |-> (out_data == in_data)); // R5

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_beat && in_last && !dir_tx) |=> ($stable(cksum_ok) && $stable(msg_illegal))); // R7

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cksum_ok && msg_illegal)); // R6

  AST_NOLINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (c_beat && in_last && !dir_tx && !link_illegal) |=> !msg_illegal); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (c_beat && in_last && !dir_tx && cksum_en_n) |=> (!cksum_ok && !msg_illegal)); // R10

  AST_DISABLED_TX_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    cksum_en_n |-> (out_data == in_data)); // R10
endmodule

bind msg_cksum_unit msg_cksum_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cksum_en_n(cksum_en_n), .link_illegal(link_illegal),
  .dir_tx(dir_tx), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .cksum_ok(cksum_ok),
  .msg_illegal(msg_illegal), .acc_q(acc_q)
);

// File: tb/msg_cksum_unit_tb.sv
`timescale 1ns/1ps
module msg_cksum_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cksum_en_n = 1'b1;
  logic        link_illegal = 1'b0;
  logic        dir_tx = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        out_last;
  logic        cksum_ok;
  logic        msg_illegal;

  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] msg [8];
  logic [15:0] last_out;

  always #2 clk = ~clk;

  msg_cksum_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cksum_en_n(cksum_en_n), .link_illegal(link_illegal),
    .dir_tx(dir_tx), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .cksum_ok(cksum_ok),
    .msg_illegal(msg_illegal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rl(input logic [15:0] x);
    return {x[14:0], x[15]};
  endfunction

  function automatic logic [15:0] fold(input int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s = rl(s) ^ msg[i];
    return s;
  endfunction

  // sends msg[0..n-1]; words before the last are checked for pass-through
  task automatic send(input int n, input bit tx);
    dir_tx = tx;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = msg[i]; in_last = (i == n - 1); out_ready = 1'b1;
      #1;
      if (i < n - 1 && (tx || !cksum_en_n)) check("R5 mid word", out_data, msg[i]);
      last_out = out_data;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic load_a();
    msg[0] = 16'h1234; msg[1] = 16'h8001; msg[2] = 16'hBEEF; msg[3] = 16'h0F0F;
  endtask

  task automatic t_reset();
    check("R1 ok after reset", cksum_ok, 0);
    check("R1 illegal after reset", msg_illegal, 0);
    cksum_en_n = 1'b0;
    msg[0] = 16'h0000;
    send(1, 1'b0);
    check("R1 zero start one-word rx", cksum_ok, 1);
  endtask

  task automatic t_tx();
    logic [15:0] exp;
    cksum_en_n = 1'b0;
    load_a(); msg[4] = 16'hAAAA;
    exp = rl(fold(4));
    send(5, 1'b1);
    check("R4 tx checksum word", last_out, exp);
    msg[4] = last_out;
    check("R3 whole tx folds zero", fold(5), 0);
    msg[0] = 16'h5A5A;
    send(1, 1'b1);
    check("R4 one-word tx", last_out, 16'h0000);
  endtask

  task automatic t_rx_good();
    cksum_en_n = 1'b0; link_illegal = 1'b1;
    load_a(); msg[4] = rl(fold(4));
    send(5, 1'b0);
    check("R6 good rx ok", cksum_ok, 1);
    check("R8 good rx illegal", msg_illegal, 0);
  endtask

  task automatic t_rx_bad(input bit link);
    cksum_en_n = 1'b0; link_illegal = link;
    load_a(); msg[4] = rl(fold(4)) ^ 16'h0100;
    send(5, 1'b0);
    check("R6 bad rx ok", cksum_ok, 0);
    if (link) check("R8 linked fail illegal", msg_illegal, 1);
    else      check("R9 unlinked fail illegal", msg_illegal, 0);
  endtask

  task automatic t_tx_keeps_flags();
    cksum_en_n = 1'b0; link_illegal = 1'b1;
    load_a(); msg[3] = 16'h7777;
    send(4, 1'b0);
    check("R7 setup illegal", msg_illegal, 1);
    load_a();
    send(4, 1'b1);
    check("R7 tx keeps illegal", msg_illegal, 1);
    check("R7 tx keeps ok", cksum_ok, 0);
  endtask

  task automatic t_disabled();
    cksum_en_n = 1'b1; link_illegal = 1'b1;
    load_a();
    send(4, 1'b1);
    check("R10 disabled tx last thru", last_out, 16'h0F0F);
    msg[3] = rl(fold(3));
    send(4, 1'b0);
    check("R10 disabled rx ok", cksum_ok, 0);
    check("R10 disabled rx illegal", msg_illegal, 0);
  endtask

  task automatic t_backpressure();
    cksum_en_n = 1'b0; link_illegal = 1'b0; dir_tx = 1'b0;
    load_a(); msg[4] = rl(fold(4));
    @(negedge clk);
    in_valid = 1'b1; in_data = msg[0]; in_last = 1'b0; out_ready = 1'b0;
    #1;
    check("R2 ready follows", in_ready, 0);
    check("R2 valid follows", out_valid, 1);
    repeat (3) @(negedge clk);
    in_data = 16'hFFFF;
    @(negedge clk);
    in_data = msg[0];
    out_ready = 1'b1;
    for (int i = 1; i < 5; i++) begin
      @(negedge clk);
      in_data = msg[i]; in_last = (i == 4);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    check("R2 stalled word not taken", cksum_ok, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx();
    t_rx_good();
    t_rx_bad(1'b1);
    t_rx_bad(1'b0);
    t_tx_keeps_flags();
    t_disabled();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule